// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return program counters and status words of nested procedure calls in a small circular buffer. Two indices track the oldest entry (bottom) and the newest entry (top), and a counter tracks how many entries are live. A call pushes a new top entry. A return pops it. The top entry's PC and status are always on the outputs, so the fetch unit can redirect on a return without waiting.

Privileged software can also reach the stack through a register-style port. It has four selectable registers: bottom PC, bottom status, top PC and top status.
- Reading the bottom-PC register removes the oldest entry.
- Writing the bottom-PC register creates a new entry below the oldest one.
- The other three registers are read and written in place.

These two bottom-PC operations let a trap handler spill the stack from its old end and refill it later. A push that would take the count past a parameterised threshold is refused and raises an overflow trap. Privileged accesses made in user mode raise a mode fault. Register accesses take a fixed number of extra cycles, which is reported through busy/done.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the entry count is 0, `ret_pc_o`/`ret_st_o` are 0, and `ovf_trap_o`, `stk_err_o`, `acc_busy_o`, `acc_done_o`, `acc_fault_o` and `acc_rdata_o` are all 0.
- R2: A call made while the count is below `OVF_LIMIT` stores `call_pc_i`/`call_st_i` as the new top entry and increments the count. From the next cycle `ret_pc_o`/`ret_st_o` show the top entry whenever the count is non-zero, and show 0 when it is zero.
- R3: A call made while the count is at or above `OVF_LIMIT` changes nothing, and `ovf_trap_o` is high for exactly the next cycle. The count therefore never exceeds `OVF_LIMIT`.
- R4: A return removes the top entry and decrements the count. A return on an empty stack changes nothing, and `stk_err_o` is high for the next cycle.
- R5: Only one command is acted on per cycle, with priority call, then return, then register access. An access request is dropped when a call or return is present in the same cycle, and also while `acc_busy_o` is high. A dropped access produces no `acc_done_o` and no state change.
- R6: A kernel read of selector 0 (bottom PC) returns the oldest entry's PC, removes that entry, and decrements the count.
- R7: A kernel write of selector 0 creates a new oldest entry below the current one, with PC = `acc_wdata_i` and status 0, and increments the count. When the count is at or above `OVF_LIMIT`, the write is refused exactly as in R3.
- R8: Selectors 1 (bottom status), 2 (top PC) and 3 (top status) read or overwrite that field in place, without changing the count or the order of entries.
- R9: On an empty stack, any access other than a selector-0 write has no effect, returns read data 0, and pulses `stk_err_o` for the next cycle.
- R10: In user mode, any write and any selector-0 read is refused. The refused access completes with `acc_fault_o` = 1 and read data 0, and the state is unchanged. User-mode reads of selectors 1 to 3 behave as in R8.
- R11: An accepted access asserts `acc_done_o` for one cycle, exactly `ACC_EXTRA` cycles after the request cycle. `acc_busy_o` is high from the cycle after the request through the done cycle. `acc_rdata_o`/`acc_fault_o` carry the result only in the done cycle and are 0 otherwise.
- R12: Entry order is preserved across index wrap-around: returns give last-in first-out order, and bottom-PC reads give oldest-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Push request (procedure call) |
| call_pc_i | input | W | Return PC to push |
| call_st_i | input | W | Status word to push |
| ret_i | input | 1 | Pop request (procedure return) |
| acc_req_i | input | 1 | Register access request |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 2 | 0 bottom PC, 1 bottom status, 2 top PC, 3 top status |
| acc_wdata_i | input | W | Write data |
| user_mode_i | input | 1 | Requester is in user mode |
| ret_pc_o | output | W | Top entry PC (0 when empty) |
| ret_st_o | output | W | Top entry status (0 when empty) |
| depth_o | output | $clog2(DEPTH+1) | Live entry count |
| ovf_trap_o | output | 1 | Refused push, one-cycle pulse |
| stk_err_o | output | 1 | Pop or access on empty stack, one-cycle pulse |
| acc_busy_o | output | 1 | Access in progress |
| acc_done_o | output | 1 | Access result valid |
| acc_rdata_o | output | W | Access read data |
| acc_fault_o | output | 1 | Access refused for user mode |

## Verification
The stack is driven through four patterns:
- Pure call runs up to and past the threshold, and pure return runs down to and past empty. These separate the threshold compare from the empty compare.
- Bottom-PC writes that fill the stack from below, followed by bottom-PC reads that drain it. These show that the bottom index moves in the opposite direction to the top index, and that the fill reaches the same overflow limit.
- A marching window of calls interleaved with bottom reads, which wraps both indices several times. Wrong modular stepping or a lost order then shows up in the top and bottom values.
- Every selector in kernel mode and in user mode, on a populated stack and on an empty one, plus accesses colliding with calls or issued while busy. These tell the fault, the empty error and the dropped-request paths apart.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        SEL_OLD_PC = 2'd0,
        SEL_OLD_ST = 2'd1,
        SEL_NEW_PC = 2'd2,
        SEL_NEW_ST = 2'd3
    } rstk_sel_e;

endpackage

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_pc_i,
    input  logic             we_st_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [W-1:0]     wpc_i,
    input  logic [W-1:0]     wst_i,
    input  logic [IDX_W-1:0] old_idx_i,
    input  logic [IDX_W-1:0] new_idx_i,
    output logic [W-1:0]     old_pc_o,
    output logic [W-1:0]     old_st_o,
    output logic [W-1:0]     new_pc_o,
    output logic [W-1:0]     new_st_o
);

    logic [W-1:0] pc_q [DEPTH];
    logic [W-1:0] st_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [W-1:0] pc_d, st_d;
        logic         hit;

        always_comb begin
            hit  = (waddr_i == IDX_W'(e));
            pc_d = pc_q[e];
            st_d = st_q[e];
            if (hit && we_pc_i) pc_d = wpc_i;
            if (hit && we_st_i) st_d = wst_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[e] <= '0;
                st_q[e] <= '0;
            end else begin
                pc_q[e] <= pc_d;
                st_q[e] <= st_d;
            end
        end
    end

    assign old_pc_o = pc_q[old_idx_i];
    assign old_st_o = st_q[old_idx_i];
    assign new_pc_o = pc_q[new_idx_i];
    assign new_st_o = st_q[new_idx_i];

endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int W         = 16,
    parameter int OVF_LIMIT = DEPTH - 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic [W-1:0]     call_pc_i,
    input  logic [W-1:0]     call_st_i,
    input  logic             ret_i,
    input  logic             acc_req_i,
    input  logic             acc_wr_i,
    input  logic [1:0]       acc_sel_i,
    input  logic [W-1:0]     acc_wdata_i,
    input  logic             user_mode_i,
    input  logic             busy_i,
    input  logic [W-1:0]     old_pc_i,
    input  logic [W-1:0]     old_st_i,
    input  logic [W-1:0]     new_pc_i,
    input  logic [W-1:0]     new_st_i,
    output logic [IDX_W-1:0] old_idx_o,
    output logic [IDX_W-1:0] new_idx_o,
    output logic [CNT_W-1:0] count_o,
    output logic             we_pc_o,
    output logic             we_st_o,
    output logic [IDX_W-1:0] waddr_o,
    output logic [W-1:0]     wpc_o,
    output logic [W-1:0]     wst_o,
    output logic             acc_go_o,
    output logic [W-1:0]     acc_rdata_o,
    output logic             acc_fault_o,
    output logic             ovf_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] LIM  = CNT_W'(OVF_LIMIT);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] eldest;
        logic [IDX_W-1:0] youngest;
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             err;
    } ctrl_st_t;

    ctrl_st_t  s_d, s_q;
    rstk_sel_e sel;
    logic      full, empty;

    function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] x);
        return (x == LAST) ? '0 : x + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] step_dn(input logic [IDX_W-1:0] x);
        return (x == '0) ? LAST : x - 1'b1;
    endfunction

    assign sel   = rstk_sel_e'(acc_sel_i);
    assign full  = (s_q.count >= LIM);
    assign empty = (s_q.count == '0);

    always_comb begin
        s_d         = s_q;
        s_d.ovf     = 1'b0;
        s_d.err     = 1'b0;
        we_pc_o     = 1'b0;
        we_st_o     = 1'b0;
        waddr_o     = s_q.youngest;
        wpc_o       = call_pc_i;
        wst_o       = call_st_i;
        acc_go_o    = 1'b0;
        acc_rdata_o = '0;
        acc_fault_o = 1'b0;

        if (call_i) begin
            if (full) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.youngest = step_up(s_q.youngest);
                s_d.count    = s_q.count + 1'b1;
                waddr_o      = step_up(s_q.youngest);
                we_pc_o      = 1'b1;
                we_st_o      = 1'b1;
            end
        end else if (ret_i) begin
            if (empty) begin
                s_d.err = 1'b1;
            end else begin
                s_d.youngest = step_dn(s_q.youngest);
                s_d.count    = s_q.count - 1'b1;
            end
        end else if (acc_req_i && !busy_i) begin
            acc_go_o = 1'b1;
            if (user_mode_i && (acc_wr_i || sel == SEL_OLD_PC)) begin
                acc_fault_o = 1'b1;
            end else if (acc_wr_i && sel == SEL_OLD_PC) begin
                if (full) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.eldest = step_dn(s_q.eldest);
                    s_d.count  = s_q.count + 1'b1;
                    waddr_o    = step_dn(s_q.eldest);
                    wpc_o      = acc_wdata_i;
                    wst_o      = '0;
                    we_pc_o    = 1'b1;
                    we_st_o    = 1'b1;
                end
            end else if (empty) begin
                s_d.err = 1'b1;
            end else begin
                unique case (sel)
                    SEL_OLD_PC: begin
                        acc_rdata_o = old_pc_i;
                        s_d.eldest  = step_up(s_q.eldest);
                        s_d.count   = s_q.count - 1'b1;
                    end
                    SEL_OLD_ST: begin
                        waddr_o = s_q.eldest;
                        wst_o   = acc_wdata_i;
                        we_st_o = acc_wr_i;
                        if (!acc_wr_i) acc_rdata_o = old_st_i;
                    end
                    SEL_NEW_PC: begin
                        wpc_o   = acc_wdata_i;
                        we_pc_o = acc_wr_i;
                        if (!acc_wr_i) acc_rdata_o = new_pc_i;
                    end
                    default: begin
                        wst_o   = acc_wdata_i;
                        we_st_o = acc_wr_i;
                        if (!acc_wr_i) acc_rdata_o = new_st_i;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.eldest   <= '0;
            s_q.youngest <= LAST;
            s_q.count    <= '0;
            s_q.ovf      <= 1'b0;
            s_q.err      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign old_idx_o = s_q.eldest;
    assign new_idx_o = s_q.youngest;
    assign count_o   = s_q.count;
    assign ovf_o     = s_q.ovf;
    assign err_o     = s_q.err;

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= LIM);

    assert_ptr_link_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.youngest) == (int'(s_q.eldest) + int'(s_q.count) + DEPTH - 1) % DEPTH);

    assert_refuse_call_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && full) |=> (ovf_o && $stable(count_o)));

    assert_empty_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && ret_i && empty) |=> (err_o && count_o == '0));

    assert_user_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go_o && user_mode_i && acc_wr_i) |=>
            ($stable(count_o) && $stable(old_idx_o) && $stable(new_idx_o)));

endmodule

// File: rtl/rstk_lat.sv
module rstk_lat #(
    parameter int W     = 16,
    parameter int EXTRA = 4,
    localparam int CW = $clog2(EXTRA + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] rdata_i,
    input  logic         fault_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] rdata_o,
    output logic         fault_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  rdata;
        logic          fault;
    } lat_st_t;

    lat_st_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (go_i) begin
            l_d.cnt   = CW'(EXTRA);
            l_d.rdata = rdata_i;
            l_d.fault = fault_i;
        end else if (l_q.cnt != '0) begin
            l_d.cnt = l_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign busy_o  = (l_q.cnt != '0);
    assign done_o  = (l_q.cnt == CW'(1));
    assign rdata_o = done_o ? l_q.rdata : '0;
    assign fault_o = done_o & l_q.fault;

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int DEPTH     = 8,
    parameter int W         = 16,
    parameter int OVF_LIMIT = DEPTH - 2,
    parameter int ACC_EXTRA = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_i,
    input  logic [W-1:0]     call_pc_i,
    input  logic [W-1:0]     call_st_i,
    input  logic             ret_i,
    input  logic             acc_req_i,
    input  logic             acc_wr_i,
    input  logic [1:0]       acc_sel_i,
    input  logic [W-1:0]     acc_wdata_i,
    input  logic             user_mode_i,
    output logic [W-1:0]     ret_pc_o,
    output logic [W-1:0]     ret_st_o,
    output logic [CNT_W-1:0] depth_o,
    output logic             ovf_trap_o,
    output logic             stk_err_o,
    output logic             acc_busy_o,
    output logic             acc_done_o,
    output logic [W-1:0]     acc_rdata_o,
    output logic             acc_fault_o
);

    logic [IDX_W-1:0] old_idx, new_idx, waddr;
    logic [W-1:0]     old_pc, old_st, new_pc, new_st, wpc, wst, rd_now;
    logic             we_pc, we_st, go, fault_now;

    rstk_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_pc_i(we_pc), .we_st_i(we_st), .waddr_i(waddr),
        .wpc_i(wpc), .wst_i(wst),
        .old_idx_i(old_idx), .new_idx_i(new_idx),
        .old_pc_o(old_pc), .old_st_o(old_st),
        .new_pc_o(new_pc), .new_st_o(new_st)
    );

    rstk_ctrl #(.DEPTH(DEPTH), .W(W), .OVF_LIMIT(OVF_LIMIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_i(call_i), .call_pc_i(call_pc_i), .call_st_i(call_st_i),
        .ret_i(ret_i),
        .acc_req_i(acc_req_i), .acc_wr_i(acc_wr_i), .acc_sel_i(acc_sel_i),
        .acc_wdata_i(acc_wdata_i), .user_mode_i(user_mode_i),
        .busy_i(acc_busy_o),
        .old_pc_i(old_pc), .old_st_i(old_st), .new_pc_i(new_pc), .new_st_i(new_st),
        .old_idx_o(old_idx), .new_idx_o(new_idx), .count_o(depth_o),
        .we_pc_o(we_pc), .we_st_o(we_st), .waddr_o(waddr),
        .wpc_o(wpc), .wst_o(wst),
        .acc_go_o(go), .acc_rdata_o(rd_now), .acc_fault_o(fault_now),
        .ovf_o(ovf_trap_o), .err_o(stk_err_o)
    );

    rstk_lat #(.W(W), .EXTRA(ACC_EXTRA)) u_lat (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .rdata_i(rd_now), .fault_i(fault_now),
        .busy_o(acc_busy_o), .done_o(acc_done_o),
        .rdata_o(acc_rdata_o), .fault_o(acc_fault_o)
    );

    assign ret_pc_o = (depth_o == '0) ? '0 : new_pc;
    assign ret_st_o = (depth_o == '0) ? '0 : new_st;

endmodule

// File: tb/tb_ret_addr_stack.sv
`timescale 1ns/1ps
module tb_ret_addr_stack;
    localparam int D = 8, LIM = 6, W = 16, EXT = 4, CW = $clog2(D + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic call_i = 0, ret_i = 0, acc_req_i = 0, acc_wr_i = 0, user_mode_i = 0;
    logic [W-1:0] call_pc_i = '0, call_st_i = '0, acc_wdata_i = '0;
    logic [1:0] acc_sel_i = '0;
    logic [W-1:0] ret_pc_o, ret_st_o, acc_rdata_o;
    logic [CW-1:0] depth_o;
    logic ovf_trap_o, stk_err_o, acc_busy_o, acc_done_o, acc_fault_o;

    ret_addr_stack #(.DEPTH(D), .W(W), .OVF_LIMIT(LIM), .ACC_EXTRA(EXT)) dut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [W-1:0] mpc [D];
    logic [W-1:0] mst [D];
    int me = 0, my = D - 1, mc = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(string tag);
        chk({tag, " count"}, depth_o, mc);
        chk({tag, " top pc"}, ret_pc_o, mc != 0 ? mpc[my] : 0);
        chk({tag, " top st"}, ret_st_o, mc != 0 ? mst[my] : 0);
    endtask

    task automatic do_call(string tag, logic [W-1:0] pc, logic [W-1:0] st, bit with_ret);
        bit eo;
        eo = (mc >= LIM);
        call_i = 1; call_pc_i = pc; call_st_i = st; ret_i = with_ret;
        @(negedge clk);
        call_i = 0; ret_i = 0;
        if (!eo) begin my = (my + 1) % D; mpc[my] = pc; mst[my] = st; mc++; end
        chk({tag, " ovf"}, ovf_trap_o, eo);
        chk({tag, " err"}, stk_err_o, 0);
        chk_state(tag);
    endtask

    task automatic do_ret(string tag);
        bit ee;
        ee = (mc == 0);
        ret_i = 1;
        @(negedge clk);
        ret_i = 0;
        if (!ee) begin my = (my + D - 1) % D; mc--; end
        chk({tag, " err"}, stk_err_o, ee);
        chk({tag, " ovf"}, ovf_trap_o, 0);
        chk_state(tag);
    endtask

    task automatic do_acc(string tag, bit wr, logic [1:0] sel, logic [W-1:0] data,
                          bit user, bit inject);
        logic [W-1:0] erd;
        bit ef, eo, ee;
        erd = '0; ef = 0; eo = 0; ee = 0;
        if (user && (wr || sel == 0)) ef = 1;
        else if (wr && sel == 0) begin
            if (mc >= LIM) eo = 1;
            else begin me = (me + D - 1) % D; mpc[me] = data; mst[me] = '0; mc++; end
        end else if (mc == 0) ee = 1;
        else begin
            case (sel)
                2'd0: begin erd = mpc[me]; me = (me + 1) % D; mc--; end
                2'd1: if (wr) mst[me] = data; else erd = mst[me];
                2'd2: if (wr) mpc[my] = data; else erd = mpc[my];
                default: if (wr) mst[my] = data; else erd = mst[my];
            endcase
        end
        acc_req_i = 1; acc_wr_i = wr; acc_sel_i = sel; acc_wdata_i = data; user_mode_i = user;
        @(negedge clk);
        if (inject) begin
            acc_wr_i = 1; acc_sel_i = 2'd2; acc_wdata_i = 16'hDEAD; user_mode_i = 0;
        end else acc_req_i = 0;
        chk({tag, " ovf"}, ovf_trap_o, eo);
        chk({tag, " err"}, stk_err_o, ee);
        for (int i = 1; i <= EXT; i++) begin
            if (i > 1) begin acc_req_i = 0; user_mode_i = 0; end
            chk({tag, " R11 busy"}, acc_busy_o, 1);
            chk({tag, " R11 done"}, acc_done_o, i == EXT);
            if (i == EXT) begin
                chk({tag, " rdata"}, acc_rdata_o, erd);
                chk({tag, " fault"}, acc_fault_o, ef);
            end else
                chk({tag, " R11 rdata idle"}, acc_rdata_o, 0);
            @(negedge clk);
        end
        chk({tag, " R11 idle"}, acc_busy_o, 0);
        chk({tag, " R11 done low"}, acc_done_o, 0);
        chk_state(tag);
    endtask

    task automatic do_acc_with_call(string tag, logic [W-1:0] pc);
        bit eo;
        eo = (mc >= LIM);
        call_i = 1; call_pc_i = pc; call_st_i = pc ^ 16'h0F0F;
        acc_req_i = 1; acc_wr_i = 0; acc_sel_i = 2'd0; user_mode_i = 0;
        @(negedge clk);
        call_i = 0; acc_req_i = 0;
        if (!eo) begin my = (my + 1) % D; mpc[my] = pc; mst[my] = pc ^ 16'h0F0F; mc++; end
        for (int i = 0; i < EXT + 1; i++) begin
            chk({tag, " no done"}, acc_done_o, 0);
            chk({tag, " no busy"}, acc_busy_o, 0);
            @(negedge clk);
        end
        chk_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < D; k++) begin mpc[k] = '0; mst[k] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", depth_o, 0);
        chk("R1 top pc", ret_pc_o, 0);
        chk("R1 top st", ret_st_o, 0);
        chk("R1 ovf", ovf_trap_o, 0);
        chk("R1 err", stk_err_o, 0);
        chk("R1 busy", acc_busy_o, 0);
        chk("R1 done", acc_done_o, 0);
        chk("R1 rdata", acc_rdata_o, 0);
        chk("R1 fault", acc_fault_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 fill by calls, R3 at the limit
        for (int i = 0; i <= LIM; i++)
            do_call(i < LIM ? "R2 push" : "R3 push refused", 16'h100 + 16'(i), 16'h50 + 16'(i), 0);
        do_call("R5 call beats ret at limit", 16'h1FF, 16'h1EE, 1);
        // R4 drain, then pop on empty
        for (int i = 0; i <= LIM; i++) do_ret("R4 pop");

        // R5 call and access in the same cycle: access dropped
        do_acc_with_call("R5 access dropped", 16'h321);
        do_call("R5 call beats ret", 16'h322, 16'h3, 1);
        do_ret("R4 pop");
        do_ret("R4 pop");

        // R7 fill from the bottom until refused
        for (int i = 0; i <= LIM; i++)
            do_acc("R7 bottom write", 1, 2'd0, 16'h200 + 16'(i), 0, 0);

        // R8 in-place access, kernel and user reads
        do_acc("R8 read top pc", 0, 2'd2, '0, 0, 0);
        do_acc("R8 read bottom st", 0, 2'd1, '0, 0, 0);
        do_acc("R8 read top st", 0, 2'd3, '0, 0, 0);
        do_acc("R8 write bottom st", 1, 2'd1, 16'hB0B0, 0, 0);
        do_acc("R8 write top pc", 1, 2'd2, 16'hA1A1, 0, 0);
        do_acc("R8 write top st", 1, 2'd3, 16'hC2C2, 0, 0);
        for (int s = 1; s < 4; s++) do_acc("R10 user read ok", 0, 2'(s), '0, 1, 0);

        // R10 faults
        for (int s = 0; s < 4; s++) do_acc("R10 user write fault", 1, 2'(s), 16'hFFFF, 1, 0);
        do_acc("R10 user bottom read fault", 0, 2'd0, '0, 1, 0);

        // R5 request while busy is dropped
        do_acc("R5 busy drop", 1, 2'd3, 16'h0077, 0, 1);
        do_acc("R5 busy drop readback", 0, 2'd2, '0, 0, 0);

        // R6 drain from the bottom, then R9 on empty
        while (mc > 0) do_acc("R6 bottom read", 0, 2'd0, '0, 0, 0);
        for (int s = 0; s < 4; s++) do_acc("R9 empty read", 0, 2'(s), '0, 0, 0);
        for (int s = 1; s < 4; s++) do_acc("R9 empty write", 1, 2'(s), 16'h5A5A, 0, 0);

        // R12 marching window wraps both indices
        for (int r = 0; r < 20; r++) begin
            do_call("R12 wrap push", 16'h400 + 16'(r), 16'h40 + 16'(r), 0);
            if (mc >= 3) do_acc("R12 wrap bottom read", 0, 2'd0, '0, 0, 0);
        end
        while (mc > 0) do_ret("R12 wrap pop");

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule